// File: doc/BRIEF.md
# Length-32 Parallel Polar Encoder

This block turns a 32-bit information word into a length-32 polar codeword in one pass through a purely combinational XOR network. The network has five butterfly stages. Each stage holds sixteen two-input kernels, and each kernel emits the XOR of its pair on the lower index and passes the upper input through unchanged. That is 80 XOR gates in total. Stage s pairs indices that are 2^(s-1) apart.

The input word is taken in natural index order. The codeword comes out in bit-reversed order, so no permutation network is needed anywhere in the path. The word is captured into an input register and crosses the network within one clock period. The result lands in an output register next to a valid flag. A new word can be accepted on every cycle.

The block is meant to sit behind the stage that places frozen and information bits. Its output feeds the transmit path.

Top module: `polar_enc_par`

## Requirements
- R1: Bit j of `codeword_o` equals the XOR of every `data_i` bit i whose index contains all set bits of j, that is (i & j) == j. This is the natural-order product of u with the fifth Kronecker power of [[1,0],[1,1]], which is the standard codeword with bit-reversed indices.
- R2: When `in_valid_i` is high at rising edge k, `out_valid_o` is high after edge k+1 for exactly one cycle, carrying that word's codeword. Words offered on consecutive cycles come out on consecutive cycles in the same order.
- R3: While `out_valid_o` is low, `codeword_o` keeps its previous value.
- R4: While `rst_ni` is low, `out_valid_o` and `codeword_o` are 0. A word in flight when reset is applied never appears at the output.
- R5: `data_i` is ignored while `in_valid_i` is low: no valid output results, and the codeword already presented does not change.
- R6: Corner words: all-zero gives all-zero; all-ones (0xFFFFFFFF) gives only bit 31 (0x80000000); a single 1 at index i gives ones exactly at the indices j with (i & j) == j, so index 31 gives all-ones and index 0 gives 0x00000001.
- R7: The transform is its own inverse: feeding a codeword back in as data returns the original information word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Qualifies `data_i` on this edge |
| data_i | input | 32 | Information word, natural index order |
| out_valid_o | output | 1 | Codeword on `codeword_o` is new this cycle |
| codeword_o | output | 32 | Encoded word, bit-reversed index order |

## Verification
The checker tests the mapping from the captured word to the codeword against an independent subset-XOR model on every valid cycle. On every cycle it also checks the two-edge valid latency, that the output holds while idle, and that the outputs are cleared while reset is low. Only the bench scenarios can show the named corner words and single-hot patterns with known values, the self-inverse round trip, streaming order under back-to-back input, and that a word in flight is discarded by a mid-flight reset.

// File: rtl/polar_enc_pkg.sv
package polar_enc_pkg;

  localparam int unsigned DEF_LEN = 32;

  // lower index of kernel p in stage s (0-based): insert a 0 at bit s
  function automatic int unsigned pair_lo(input int unsigned p, input int unsigned s);
    int unsigned low_mask;
    low_mask = (32'd1 << s) - 32'd1;
    return ((p >> s) << (s + 32'd1)) | (p & low_mask);
  endfunction

endpackage

// File: rtl/polar_kernel.sv
module polar_kernel (
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic pass_o
);
  assign sum_o  = a_i ^ b_i;
  assign pass_o = b_i;
endmodule

// File: rtl/polar_stage.sv
module polar_stage #(
  parameter int unsigned N_BITS = 32,
  parameter int unsigned STG    = 0
) (
  input  logic [N_BITS-1:0] d_i,
  output logic [N_BITS-1:0] d_o
);
  localparam int unsigned HALF = N_BITS / 2;
  localparam int unsigned SPAN = 32'd1 << STG;

  for (genvar p = 0; p < HALF; p++) begin : g_kern
    localparam int unsigned LO = polar_enc_pkg::pair_lo(p, STG);
    localparam int unsigned HI = LO + SPAN;
    polar_kernel u_kern (
      .a_i   (d_i[LO]),
      .b_i   (d_i[HI]),
      .sum_o (d_o[LO]),
      .pass_o(d_o[HI])
    );
  end
endmodule

// File: rtl/polar_network.sv
module polar_network #(
  parameter int unsigned N_BITS = 32
) (
  input  logic [N_BITS-1:0] u_i,
  output logic [N_BITS-1:0] x_o
);
  localparam int unsigned N_STG = $clog2(N_BITS);

  logic [N_BITS-1:0] lvl [N_STG+1];

  assign lvl[0] = u_i;

  for (genvar s = 0; s < N_STG; s++) begin : g_stg
    polar_stage #(.N_BITS(N_BITS), .STG(s)) u_stage (
      .d_i(lvl[s]),
      .d_o(lvl[s+1])
    );
  end

  assign x_o = lvl[N_STG];
endmodule

// File: rtl/polar_enc_par.sv
module polar_enc_par #(
  parameter int unsigned N_BITS = polar_enc_pkg::DEF_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [N_BITS-1:0] data_i,
  output logic              out_valid_o,
  output logic [N_BITS-1:0] codeword_o
);
  logic [N_BITS-1:0] in_q;
  logic              in_vld_q;
  logic [N_BITS-1:0] net_x;
  logic [N_BITS-1:0] cw_q;
  logic              out_vld_q;

  // capture only qualified words; idle inputs never reach the network
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q     <= '0;
      in_vld_q <= 1'b0;
    end else begin
      in_vld_q <= in_valid_i;
      if (in_valid_i) in_q <= data_i;
    end
  end

  polar_network #(.N_BITS(N_BITS)) u_net (
    .u_i(in_q),
    .x_o(net_x)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cw_q      <= '0;
      out_vld_q <= 1'b0;
    end else begin
      out_vld_q <= in_vld_q;
      if (in_vld_q) cw_q <= net_x;
    end
  end

  assign out_valid_o = out_vld_q;
  assign codeword_o  = cw_q;
endmodule

// File: rtl/polar_enc_chk.sv
module polar_enc_chk #(
  parameter int unsigned N_BITS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [N_BITS-1:0] data_i,
  input logic              out_valid_o,
  input logic [N_BITS-1:0] codeword_o
);
  logic              v1, v2;
  logic [N_BITS-1:0] p1, p2;

  function automatic logic [N_BITS-1:0] subset_xor(input logic [N_BITS-1:0] u);
    logic [N_BITS-1:0] x;
    x = '0;
    for (int j = 0; j < N_BITS; j++)
      for (int i = 0; i < N_BITS; i++)
        if ((i & j) == j) x[j] = x[j] ^ u[i];
    return x;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; v2 <= 1'b0; p1 <= '0; p2 <= '0;
    end else begin
      v1 <= in_valid_i; v2 <= v1; p1 <= data_i; p2 <= p1;
    end
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == v2);

  // R1
  codeword_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> codeword_o == subset_xor(p2));

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(codeword_o));

  // R4
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (!out_valid_o && codeword_o == '0);
    end
  end
endmodule

bind polar_enc_par polar_enc_chk #(.N_BITS(N_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .data_i     (data_i),
  .out_valid_o(out_valid_o),
  .codeword_o (codeword_o)
);

// File: tb/sim_polar_enc_par.sv
`timescale 1ns/1ps
module sim_polar_enc_par;
  localparam int W = 32;

  // {data, expected codeword}, values from R6 and R1
  localparam logic [63:0] VEC [9] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'h8000_0000},
    {32'h8000_0000, 32'hFFFF_FFFF},
    {32'h0000_0001, 32'h0000_0001},
    {32'h0000_0002, 32'h0000_0003},
    {32'h0000_0003, 32'h0000_0002},
    {32'h0000_0004, 32'h0000_0005},
    {32'h0001_0000, 32'h0001_0001},
    {32'h8000_0001, 32'hFFFF_FFFE}
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] data = '0;
  logic         out_valid;
  logic [W-1:0] codeword;
  int           n_chk = 0;
  int           n_bad = 0;
  logic [W-1:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  polar_enc_par #(.N_BITS(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .data_i(data),
    .out_valid_o(out_valid), .codeword_o(codeword)
  );

  function automatic logic [W-1:0] ref_enc(input logic [W-1:0] u);
    logic [W-1:0] x = '0;
    for (int j = 0; j < W; j++)
      for (int i = 0; i < W; i++)
        if ((i & j) == j) x[j] = x[j] ^ u[i];
    return x;
  endfunction

  function automatic logic [W-1:0] next_rng(input logic [W-1:0] s);
    logic [W-1:0] t = s;
    t = t ^ (t << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one isolated word; returns codeword seen after the second edge
  task automatic enc(input logic [W-1:0] w, output logic [W-1:0] cw, output logic vld);
    @(negedge clk); data = w; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0; data = ~w;
    @(negedge clk); vld = out_valid; cw = codeword;
  endtask

  task automatic enc_check(input string req, input logic [W-1:0] w, input logic [W-1:0] exp);
    logic [W-1:0] cw; logic vld;
    enc(w, cw, vld);
    check({req, " valid"}, {31'd0, vld}, 32'd1);
    check(req, cw, exp);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] cw, held, w, m;
    logic vld;
    logic [W-1:0] stream [8];

    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R4 reset state
    check("R4 reset valid", {31'd0, out_valid}, 32'd0);
    check("R4 reset codeword", codeword, 32'd0);
    rst_ni = 1'b1;

    // table walk: R6 corner words and R1 known values
    foreach (VEC[k]) enc_check("R6/R1 table", VEC[k][63:32], VEC[k][31:0]);

    // R3: one cycle later the flag drops and the word holds
    held = codeword;
    @(negedge clk);
    check("R3 valid low", {31'd0, out_valid}, 32'd0);
    check("R3 hold", codeword, held);

    // R6 single-hot sweep
    for (int i = 0; i < W; i++) begin
      m = '0;
      for (int j = 0; j < W; j++) if ((i & j) == j) m[j] = 1'b1;
      enc_check("R6 single-hot", 32'd1 << i, m);
    end

    // R1 random words
    for (int k = 0; k < 32; k++) begin
      rng = next_rng(rng);
      enc_check("R1 random", rng, ref_enc(rng));
    end

    // R7 round trip
    for (int k = 0; k < 4; k++) begin
      rng = next_rng(rng);
      enc(rng, cw, vld);
      enc(cw, w, vld);
      check("R7 inverse", w, rng);
    end

    // R2 back-to-back streaming
    for (int k = 0; k < 8; k++) begin rng = next_rng(rng); stream[k] = rng; end
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        check("R2 stream valid", {31'd0, out_valid}, 32'd1);
        check("R2 stream order", codeword, ref_enc(stream[k-2]));
      end
      if (k < 8) begin data = stream[k]; in_valid = 1'b1; end
      else in_valid = 1'b0;
    end

    // R5: data toggles with in_valid low
    @(negedge clk);
    held = codeword;
    for (int k = 0; k < 4; k++) begin
      data = next_rng(data);
      @(negedge clk);
      check("R5 no valid", {31'd0, out_valid}, 32'd0);
      check("R5 codeword held", codeword, held);
    end

    // R4: reset with a word in flight
    @(negedge clk); data = 32'hDEAD_BEEF; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0; rst_ni = 1'b0;
    #1;
    check("R4 mid reset codeword", codeword, 32'd0);
    @(negedge clk); rst_ni = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R4 flight dropped", {31'd0, out_valid}, 32'd0);
    end
    enc_check("R4 after reset", 32'h0000_00FF, ref_enc(32'h0000_00FF));

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule